// File: doc/BRIEF.md
# S/PDIF Receiver Enable Sequencer and Interrupt Controller

This block controls a digital audio receiver's front end. Through a two-bit enable field it moves the receiver from off, through locking onto the incoming stream, into full reception. It gathers the line decoder's events into a status register. A mask register selects which of those events drive one interrupt line. A write-one-to-clear register acknowledges the recoverable flags. The line decoder is not part of this block. It appears only as single-cycle event inputs and as sample and control words with valid strobes.

Software writes the enable field to 01 to lock only, or to 11 to lock and then capture samples. An optional wait-for-activity bit keeps the locker idle until the line toggles, so an unconnected input produces no lock errors. A two-bit retry field sets how many failed lock attempts are tolerated. A frame error, a timeout, or running out of retries halts the receiver. It stays halted until software writes the enable field back to 00, and that write also wipes the three fatal flags.

Top module: `sprx_ctrl`

## Requirements
- R1: After reset the phase output is 0 (off), `receiving` and `irq` are low, and the config (address 0), mask (address 1) and status (address 2) registers all read 0.
- R2: The enable field is config bits [1:0]. Codes 00 and 10 force phase 0. Code 01 goes to phase 2 (locking), and a sync-done event there moves it to phase 3 (locked, not receiving). Code 11 goes through locking to phase 4 (receiving, `receiving` high). Writing 01 while in phase 4 returns to phase 3.
- R3: Status bit 5 (sync done) is set by a sync-done event in phase 2. Bit 4 (block start) is set by a block event in phase 3 or 4. Bit 2 (parity) is set by a parity event in phase 4 only.
- R4: An accepted sample (phase 4) is held at address 4 and sets status bit 0. Reading address 4 clears bit 0. A control word (phase 3 or 4) is held at address 5 and sets bit 1, which reading address 5 clears. The clear register has no effect on bits 0 and 1.
- R5: A sample that arrives while bit 0 is set and address 4 is not being read sets status bit 3 (overrun) and is dropped. Address 4 keeps the earlier sample.
- R6: Writing 1 to bits 2, 3, 4 and 5 of the clear register (address 3) clears status bits 2, 3, 4 and 5. Writing to its bits 6 to 8 changes nothing.
- R7: `irq` is high when any status bit 0 to 5 is set with the same mask bit set, or when any of status bits 6 to 8 is set with mask bit 6 set. Mask bits are [6:0] of address 1.
- R8: Retry codes (config bits [5:4]) 00, 01, 10 and 11 allow 0, 3, 15 and 63 failed lock attempts. The next failure in phase 2 sets status bit 7 (sync error) and moves to phase 5 (halted).
- R9: With config bit 2 set, enabling enters phase 1. Lock failures there raise no sync error, and a line transition moves to phase 2.
- R10: A frame event (status bit 6) or timeout event (status bit 8) in phases 2 to 4 moves to phase 5, where samples are ignored. Phase 5 holds until the enable field is 00. Writing 00 clears status bits 6 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (read side effects) |
| addr | input | 3 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| lineEdge | input | 1 | Line transition seen |
| evSyncDone | input | 1 | Decoder locked |
| evSyncFail | input | 1 | One lock attempt failed |
| evBlockStart | input | 1 | Block start detected |
| evParityErr | input | 1 | Parity error on a subframe |
| evFrameErr | input | 1 | Frame error |
| evTimeout | input | 1 | Timeout error |
| sampleValid | input | 1 | New audio sample |
| sampleIn | input | DATA_W | Audio sample |
| ctrlValid | input | 1 | New control word |
| ctrlIn | input | CTRL_W | Channel-status and user bits |
| phase | output | 3 | Sequencer phase (0 off, 1 wait, 2 locking, 3 locked, 4 receiving, 5 halted) |
| receiving | output | 1 | Sample capture active |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 24-bit sample and a 16-bit control word. Those widths let distinct patterns prove which sample survives an overrun and that the control word is held apart from the sample. The retry ceiling is fixed by the two-bit code rather than by a parameter, so all four limits, including the longest of 63 failures, are walked to the exact failure that trips the sync error.

// File: rtl/sprx_pkg.sv
`timescale 1ns/1ps
package sprx_pkg;

  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_WAITACT = 3'd1,
    PH_SYNC    = 3'd2,
    PH_LOCKED  = 3'd3,
    PH_RECV    = 3'd4,
    PH_HALT    = 3'd5
  } phase_e;

  localparam int ST_W  = 9;
  localparam int B_DNE = 0;
  localparam int B_CNE = 1;
  localparam int B_PAR = 2;
  localparam int B_OVR = 3;
  localparam int B_BLK = 4;
  localparam int B_SDN = 5;
  localparam int B_FRM = 6;
  localparam int B_SER = 7;
  localparam int B_TMO = 8;
  localparam int MASK_W = 7;

  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_MASK = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;
  localparam logic [2:0] A_CTRL = 3'd5;

  // strobes from sequencer to status datapath
  typedef struct packed {
    logic setSyncDone;
    logic setSyncErr;
    logic setFrameErr;
    logic setTimeoutErr;
    logic clrFatal;
    logic takeData;
    logic takeCtrl;
    logic takeBlk;
    logic takeParity;
  } strobe_t;

  function automatic logic [5:0] retryLimit(input logic [1:0] code);
    case (code)
      2'b00:   retryLimit = 6'd0;
      2'b01:   retryLimit = 6'd3;
      2'b10:   retryLimit = 6'd15;
      default: retryLimit = 6'd63;
    endcase
  endfunction

endpackage

// File: rtl/sprx_seq.sv
`timescale 1ns/1ps
module sprx_seq
  import sprx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  logic [5:0] cfgIn,
  input  logic       lineEdge,
  input  logic       evSyncDone,
  input  logic       evSyncFail,
  input  logic       evBlockStart,
  input  logic       evParityErr,
  input  logic       evFrameErr,
  input  logic       evTimeout,
  input  logic       sampleValid,
  input  logic       ctrlValid,
  output phase_e     phase,
  output logic [5:0] cfgWord,
  output strobe_t    str
);

  logic [1:0] enField;
  logic       waitAct;
  logic [1:0] retryCode;
  logic [5:0] failCnt;
  phase_e     phaseNxt;

  logic enOff, enFull, active, fatalEvt, syncErr, lockWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enField   <= 2'b00;
      waitAct   <= 1'b0;
      retryCode <= 2'b00;
    end else if (cfgWr) begin
      enField   <= cfgIn[1:0];
      waitAct   <= cfgIn[2];
      retryCode <= cfgIn[5:4];
    end
  end

  assign cfgWord = {retryCode, 1'b0, waitAct, enField};

  assign enOff      = (enField == 2'b00) || (enField == 2'b10);
  assign enFull     = (enField == 2'b11);
  assign active     = (phase == PH_SYNC) || (phase == PH_LOCKED) || (phase == PH_RECV);
  assign lockWindow = (phase == PH_LOCKED) || (phase == PH_RECV);
  assign fatalEvt   = active && (evFrameErr || evTimeout);
  assign syncErr    = (phase == PH_SYNC) && evSyncFail && !evSyncDone &&
                      (failCnt == retryLimit(retryCode));

  always_comb begin
    phaseNxt = phase;
    if (enOff) begin
      phaseNxt = PH_OFF;
    end else begin
      case (phase)
        PH_OFF:     phaseNxt = waitAct ? PH_WAITACT : PH_SYNC;
        PH_WAITACT: if (lineEdge) phaseNxt = PH_SYNC;
        PH_SYNC: begin
          if (fatalEvt || syncErr) phaseNxt = PH_HALT;
          else if (evSyncDone)     phaseNxt = enFull ? PH_RECV : PH_LOCKED;
        end
        PH_LOCKED: begin
          if (fatalEvt)    phaseNxt = PH_HALT;
          else if (enFull) phaseNxt = PH_RECV;
        end
        PH_RECV: begin
          if (fatalEvt)     phaseNxt = PH_HALT;
          else if (!enFull) phaseNxt = PH_LOCKED;
        end
        default: phaseNxt = PH_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_OFF;
      failCnt <= '0;
    end else begin
      phase <= phaseNxt;
      if (phase != PH_SYNC)
        failCnt <= '0;
      else if (evSyncFail && !evSyncDone && !syncErr)
        failCnt <= failCnt + 6'd1;
    end
  end

  always_comb begin
    str               = '0;
    str.setSyncDone   = (phase == PH_SYNC) && evSyncDone;
    str.setSyncErr    = syncErr;
    str.setFrameErr   = active && evFrameErr;
    str.setTimeoutErr = active && evTimeout;
    str.clrFatal      = enOff;
    str.takeData      = (phase == PH_RECV) && sampleValid;
    str.takeCtrl      = lockWindow && ctrlValid;
    str.takeBlk       = lockWindow && evBlockStart;
    str.takeParity    = (phase == PH_RECV) && evParityErr;
  end

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HALT && !enOff) |=> (phase == PH_HALT));

  // R2
  recv_full_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RECV) |-> ($past(enField) == 2'b11));

  // R9
  waitact_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAITACT && !lineEdge && !enOff) |=> (phase == PH_WAITACT));

  // R8
  syncerr_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.setSyncErr && !enOff) |=> (phase == PH_HALT));

endmodule

// File: rtl/sprx_stat_path.sv
`timescale 1ns/1ps
module sprx_stat_path
  import sprx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [6:0]        wrLow,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  strobe_t           str,
  input  logic [5:0]        cfgWord,
  output logic [31:0]       rdData,
  output logic              irq
);

  logic [ST_W-1:0]   stat, statNxt, setV, clrV;
  logic [MASK_W-1:0] maskReg;
  logic [DATA_W-1:0] sampleReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic dataRd, ctrlRd, clrWr, maskWr, dropSample;

  assign dataRd = rdEn && (addr == A_DATA);
  assign ctrlRd = rdEn && (addr == A_CTRL);
  assign clrWr  = wrEn && (addr == A_CLR);
  assign maskWr = wrEn && (addr == A_MASK);
  assign dropSample = str.takeData && stat[B_DNE] && !dataRd;

  always_comb begin
    setV = '0;
    clrV = '0;
    setV[B_DNE] = str.takeData;
    setV[B_CNE] = str.takeCtrl;
    setV[B_PAR] = str.takeParity;
    setV[B_OVR] = dropSample;
    setV[B_BLK] = str.takeBlk;
    setV[B_SDN] = str.setSyncDone;
    setV[B_FRM] = str.setFrameErr;
    setV[B_SER] = str.setSyncErr;
    setV[B_TMO] = str.setTimeoutErr;
    clrV[B_DNE] = dataRd;
    clrV[B_CNE] = ctrlRd;
    if (clrWr) clrV[B_SDN:B_PAR] = wrLow[B_SDN:B_PAR];
    if (str.clrFatal) clrV[B_TMO:B_FRM] = '1;
    statNxt = (stat & ~clrV) | setV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat      <= '0;
      maskReg   <= '0;
      sampleReg <= '0;
      ctrlReg   <= '0;
    end else begin
      stat <= statNxt;
      if (maskWr) maskReg <= wrLow;
      if (str.takeData && !dropSample) sampleReg <= sampleIn;
      if (str.takeCtrl) ctrlReg <= ctrlIn;
    end
  end

  assign irq = (|(stat[B_SDN:B_DNE] & maskReg[5:0])) ||
               (maskReg[6] && (|stat[B_TMO:B_FRM]));

  always_comb begin
    rdData = '0;
    case (addr)
      A_CFG:  rdData[5:0]        = cfgWord;
      A_MASK: rdData[MASK_W-1:0] = maskReg;
      A_STAT: rdData[ST_W-1:0]   = stat;
      A_DATA: rdData[DATA_W-1:0] = sampleReg;
      A_CTRL: rdData[CTRL_W-1:0] = ctrlReg;
      default: rdData = '0;
    endcase
  end

  // R5
  overrun_keeps_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stat[B_DNE] && str.takeData && !dataRd) |=> ($stable(sampleReg) && stat[B_OVR]));

  // R4
  notempty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !str.takeData) |=> !stat[B_DNE]);

  // R10
  fatal_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.clrFatal && !str.setFrameErr && !str.setTimeoutErr && !str.setSyncErr)
      |=> (stat[B_TMO:B_FRM] == 3'b000));

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irq);

endmodule

// File: rtl/sprx_ctrl.sv
`timescale 1ns/1ps
module sprx_ctrl
  import sprx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              lineEdge,
  input  logic              evSyncDone,
  input  logic              evSyncFail,
  input  logic              evBlockStart,
  input  logic              evParityErr,
  input  logic              evFrameErr,
  input  logic              evTimeout,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              ctrlValid,
  input  logic [CTRL_W-1:0] ctrlIn,
  output logic [2:0]        phase,
  output logic              receiving,
  output logic              irq
);

  phase_e     phaseQ;
  strobe_t    str;
  logic [5:0] cfgWord;
  logic       unusedHi;

  assign unusedHi = ^wrData[31:7];

  sprx_seq seq_i (
    .clk(clk), .rstN(rstN),
    .cfgWr(wrEn && (addr == A_CFG)), .cfgIn(wrData[5:0]),
    .lineEdge(lineEdge), .evSyncDone(evSyncDone), .evSyncFail(evSyncFail),
    .evBlockStart(evBlockStart), .evParityErr(evParityErr),
    .evFrameErr(evFrameErr), .evTimeout(evTimeout),
    .sampleValid(sampleValid), .ctrlValid(ctrlValid),
    .phase(phaseQ), .cfgWord(cfgWord), .str(str)
  );

  sprx_stat_path #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) path_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrLow(wrData[6:0]), .sampleIn(sampleIn), .ctrlIn(ctrlIn),
    .str(str), .cfgWord(cfgWord), .rdData(rdData), .irq(irq)
  );

  assign phase     = phaseQ;
  assign receiving = (phaseQ == PH_RECV);

endmodule

// File: tb/sprx_ctrl_tb_top.sv
`timescale 1ns/1ps
module sprx_ctrl_tb_top;

  localparam int DATA_W = 24;
  localparam int CTRL_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, rdEn = 0;
  logic [2:0] addr = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdData;
  logic lineEdge = 0, evSyncDone = 0, evSyncFail = 0, evBlockStart = 0;
  logic evParityErr = 0, evFrameErr = 0, evTimeout = 0;
  logic sampleValid = 0, ctrlValid = 0;
  logic [DATA_W-1:0] sampleIn = 0;
  logic [CTRL_W-1:0] ctrlIn = 0;
  logic [2:0] phase;
  logic receiving, irq;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sprx_ctrl #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .lineEdge(lineEdge),
    .evSyncDone(evSyncDone), .evSyncFail(evSyncFail),
    .evBlockStart(evBlockStart), .evParityErr(evParityErr),
    .evFrameErr(evFrameErr), .evTimeout(evTimeout),
    .sampleValid(sampleValid), .sampleIn(sampleIn),
    .ctrlValid(ctrlValid), .ctrlIn(ctrlIn),
    .phase(phase), .receiving(receiving), .irq(irq)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual cycles %0d expected < 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0; wrData = 0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 0;
  endtask

  // 0 edge, 1 sync done, 2 sync fail, 3 block, 4 parity, 5 frame, 6 timeout
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: lineEdge = 1;
      1: evSyncDone = 1;
      2: evSyncFail = 1;
      3: evBlockStart = 1;
      4: evParityErr = 1;
      5: evFrameErr = 1;
      default: evTimeout = 1;
    endcase
    @(negedge clk);
    {lineEdge, evSyncDone, evSyncFail, evBlockStart, evParityErr, evFrameErr, evTimeout} = '0;
  endtask

  task automatic sendSample(input logic [DATA_W-1:0] d);
    @(negedge clk);
    sampleValid = 1; sampleIn = d;
    @(negedge clk);
    sampleValid = 0;
  endtask

  task automatic sendCtrl(input logic [CTRL_W-1:0] d);
    @(negedge clk);
    ctrlValid = 1; ctrlIn = d;
    @(negedge clk);
    ctrlValid = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic enterRecv();
    wrReg(3'd0, 32'h03);
    settle();
    pulse(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 phase", {29'd0, phase}, 0);
    chk("R1 receiving/irq", {30'd0, receiving, irq}, 0);
    rdReg(3'd0, v); chk("R1 config", v, 0);
    rdReg(3'd1, v); chk("R1 mask", v, 0);
    rdReg(3'd2, v); chk("R1 status", v, 0);
  endtask

  task automatic t_modes();
    logic [31:0] v;
    wrReg(3'd0, 32'h01);
    settle();
    chk("R2 lock-only enters phase 2", {29'd0, phase}, 2);
    pulse(1);
    chk("R2 locked phase 3", {29'd0, phase}, 3);
    chk("R2 not receiving when locked", {31'd0, receiving}, 0);
    rdReg(3'd2, v); chk("R3 sync done bit5", v, 32'h20);
    wrReg(3'd0, 32'h03);
    settle();
    chk("R2 full enable phase 4", {29'd0, phase}, 4);
    chk("R2 receiving high", {31'd0, receiving}, 1);
    wrReg(3'd0, 32'h01);
    settle();
    chk("R2 back to locked", {29'd0, phase}, 3);
    wrReg(3'd0, 32'h02);
    settle();
    chk("R2 code 10 is off", {29'd0, phase}, 0);
    wrReg(3'd3, 32'h20);
    rdReg(3'd2, v); chk("R6 sync done cleared", v, 0);
  endtask

  task automatic t_data();
    logic [31:0] v;
    enterRecv();
    chk("R2 sync done with full enable to phase 4", {29'd0, phase}, 4);
    wrReg(3'd3, 32'h20);
    sendSample(24'h123456);
    rdReg(3'd2, v); chk("R4 data not-empty bit0", v, 32'h01);
    rdReg(3'd4, v); chk("R4 sample value", v, 32'h123456);
    rdReg(3'd2, v); chk("R4 read clears bit0", v, 0);
    sendSample(24'h0000AA);
    sendSample(24'h0000BB);
    rdReg(3'd2, v); chk("R5 overrun bit3", v, 32'h09);
    rdReg(3'd4, v); chk("R5 first sample kept", v, 32'hAA);
    sendCtrl(16'h5A5A);
    sendSample(24'h000077);
    pulse(4);
    pulse(3);
    rdReg(3'd2, v); chk("R3 parity bit2 and block bit4", v, 32'h1F);
    wrReg(3'd3, 32'h1FF);
    rdReg(3'd2, v); chk("R6 clear keeps bits0,1", v, 32'h03);
    rdReg(3'd5, v); chk("R4 control word", v, 32'h5A5A);
    rdReg(3'd2, v); chk("R4 control read clears bit1", v, 32'h01);
    rdReg(3'd4, v); chk("R4 newer sample after clear", v, 32'h77);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    pulse(3);
    chk("R7 no irq with mask 0", {31'd0, irq}, 0);
    wrReg(3'd1, 32'h10);
    chk("R7 irq with bit4 enabled", {31'd0, irq}, 1);
    wrReg(3'd1, 32'h2F);
    chk("R7 no irq other enables", {31'd0, irq}, 0);
    wrReg(3'd1, 32'h40);
    pulse(5);
    chk("R10 frame error halts", {29'd0, phase}, 5);
    chk("R7 grouped enable passes frame error", {31'd0, irq}, 1);
    sendSample(24'h000999);
    wrReg(3'd3, 32'h1FF);
    rdReg(3'd2, v); chk("R10 sample ignored, R6 fatal not cleared", v, 32'h40);
    settle();
    chk("R10 halt held", {29'd0, phase}, 5);
    wrReg(3'd0, 32'h00);
    settle();
    rdReg(3'd2, v); chk("R10 disable clears fatal", v, 0);
    chk("R10 off after disable", {29'd0, phase}, 0);
    chk("R7 irq low after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    enterRecv();
    pulse(6);
    chk("R10 timeout halts", {29'd0, phase}, 5);
    rdReg(3'd2, v); chk("R10 timeout bit8", v & 32'h1C0, 32'h100);
    chk("R7 irq on timeout", {31'd0, irq}, 1);
    wrReg(3'd0, 32'h00);
    settle();
    wrReg(3'd3, 32'h3C);
    rdReg(3'd2, v); chk("R10 cleared after timeout", v, 0);
  endtask

  task automatic t_retry();
    logic [31:0] v;
    for (int code = 0; code < 4; code++) begin
      int lim;
      lim = (code == 0) ? 0 : (code == 1) ? 3 : (code == 2) ? 15 : 63;
      wrReg(3'd0, (code << 4) | 32'h01);
      settle();
      for (int i = 0; i < lim; i++) pulse(2);
      rdReg(3'd2, v); chk("R8 no sync error within limit", v & 32'h80, 0);
      chk("R8 still locking", {29'd0, phase}, 2);
      pulse(2);
      rdReg(3'd2, v); chk("R8 sync error after limit", v & 32'h80, 32'h80);
      chk("R8 halted", {29'd0, phase}, 5);
      wrReg(3'd0, 32'h00);
      settle();
    end
  endtask

  task automatic t_wait();
    logic [31:0] v;
    wrReg(3'd0, 32'h05);
    settle();
    chk("R9 waiting phase 1", {29'd0, phase}, 1);
    for (int i = 0; i < 5; i++) pulse(2);
    rdReg(3'd2, v); chk("R9 no sync error while waiting", v, 0);
    chk("R9 still waiting", {29'd0, phase}, 1);
    pulse(0);
    chk("R9 activity starts locking", {29'd0, phase}, 2);
    wrReg(3'd0, 32'h00);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_data();
    t_irq();
    t_timeout();
    t_retry();
    t_wait();
    finished = 1;
    summary();
    $finish;
  end

endmodule